// File: doc/BRIEF.md
# Push-Button Wiper Stepping Controller

This block turns two active-high push-button levels, one for stepping up and one for stepping down, into moves of the wiper position of a 64-tap digital potentiometer. Each button has its own debouncer. A press counts only once the button level has stayed high without a break for a set number of clock cycles. A break during that time starts the count again, so contact bounce of any pattern is filtered out. An accepted press moves the wiper by one tap. If the button is still held after a longer hold time, the block moves the wiper again and then keeps stepping at a fixed repeat interval until the button is released.

The position is a 6-bit code that starts at midscale. There is also one extra end position beyond each end of the code range. Stepping down past code 0 enters the bottom-scale position. Stepping up past code 63 enters the top-scale position. Both end positions saturate: a further request in the same direction does nothing. A step in the other direction brings the wiper back to the nearest normal code. A lock input freezes stepping while the wiper position is being saved elsewhere. Pressing both buttons at once also freezes stepping.

Both button inputs and the lock input are assumed to be synchronous to `clk`. The three timing counts are given in clock cycles. Their defaults are 8 ms, 1 s and 140 ms at a 1 MHz clock.

Top module: `pb_wiper_ctrl`

## Requirements
- R1: After a synchronous active-low reset the wiper code is 32 (binary 100000), and `at_top`, `at_bot` and `at_end` are all low.
- R2: An up or down level that stays high for fewer than DEB_CYC consecutive sampled cycles, then drops, leaves the position unchanged.
- R3: An up level that is high for DEB_CYC consecutive sampled cycles moves the wiper up one tap on the DEB_CYC-th of those edges. Nothing else happens until the level has stayed high for a further HOLD_CYC cycles.
- R4: The down button behaves in the same way as the up button, with the same timing, but moves the wiper down one tap.
- R5: A button that is still held HOLD_CYC cycles after its accepted step produces a second step. It then produces one more step every SCAN_CYC cycles until it is released.
- R6: An up step from code 63 enters top scale: the code stays at 63 and `at_top` is high. Further up steps at top scale have no effect.
- R7: A down step from code 0 enters bottom scale: the code stays at 0 and `at_bot` is high. Further down steps at bottom scale have no effect.
- R8: A down step at top scale returns the wiper to code 63 with `at_top` low. An up step at bottom scale returns the wiper to code 0 with `at_bot` low.
- R9: While both buttons are high, no step occurs and both debounce counts are cleared. A button that stays high after the other one is released needs a full DEB_CYC high run, counted from that release, before it steps.
- R10: While `lock` is high, no step occurs and both debounce and repeat counts are cleared. A press that was in progress when `lock` went high must therefore start its DEB_CYC count again.
- R11: `at_top` and `at_bot` are never high together, and `at_end` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_up | input | 1 | Up button level, active high, synchronous |
| btn_dn | input | 1 | Down button level, active high, synchronous |
| lock | input | 1 | Freezes stepping and clears the button timers |
| wiper_code | output | CODE_W | Wiper tap code, 0 to 63 |
| at_top | output | 1 | Wiper is at the top-scale end position |
| at_bot | output | 1 | Wiper is at the bottom-scale end position |
| at_end | output | 1 | Wiper is at either end position |

## Verification
A wrong debounce or repeat count shows up at the ports as a wiper step taken one edge too early or too late, or as a missing or extra step. The bench therefore applies presses of exactly known length, sampled on both sides of every threshold, and the error appears in the settled code straight after release. A corrupted end-scale state shows at once as a wrong flag or code on `wiper_code` and the flags. It also shows on the next step, which either fails to saturate or fails to return to the right normal code. A lock or dual-press path that fails to clear the counts shows as a step that comes early in the press that follows.

// File: rtl/pb_wiper_pkg.sv
// Shared types for the push-button wiper controller.
package pb_wiper_pkg;

    // Phase of one button's press timer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // counting toward the debounce limit
        PH_HOLD = 2'd1,   // accepted; counting toward the auto-repeat start
        PH_SCAN = 2'd2    // auto-repeat; counting the repeat interval
    } press_phase_t;

endpackage

// File: rtl/pb_press_timer.sv
// One button's adaptive debouncer and auto-repeat timer.
// Emits a one-cycle step pulse on the edge where a continuous high run
// reaches DEB_CYC. If the level is still held, it pulses again HOLD_CYC
// cycles later, and after that every SCAN_CYC cycles.
// Assumes: btn is synchronous to clk, and every limit is at least 2.
// A low level or hold_off clears the timer.
module pb_press_timer
    import pb_wiper_pkg::*;
#(
    parameter int DEB_CYC  = 8000,
    parameter int HOLD_CYC = 1000000,
    parameter int SCAN_CYC = 140000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    input  logic hold_off,
    output logic step
);
    localparam int MAX_A = (DEB_CYC > HOLD_CYC) ? DEB_CYC : HOLD_CYC;
    localparam int MAX_L = (MAX_A > SCAN_CYC) ? MAX_A : SCAN_CYC;
    localparam int CNT_W = $clog2(MAX_L) + 1;

    press_phase_t     phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit_m1;
    logic             run;

    // Pick the terminal count that belongs to the current phase.
    always_comb begin
        unique case (phase)
            PH_HOLD: limit_m1 = CNT_W'(HOLD_CYC - 1);
            PH_SCAN: limit_m1 = CNT_W'(SCAN_CYC - 1);
            default: limit_m1 = CNT_W'(DEB_CYC - 1);
        endcase
    end

    assign run  = btn && !hold_off;
    assign step = run && (cnt == limit_m1);

    // Advance the run counter and phase; any break returns to the debounce phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt   <= '0;
            phase <= PH_IDLE;
        end else if (step) begin
            cnt   <= '0;
            phase <= (phase == PH_IDLE) ? PH_HOLD : PH_SCAN;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R10: a hold-off cycle leaves the timer empty on the next cycle.
    a_r10_holdoff_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off |=> (cnt == '0 && phase == PH_IDLE));

    // R3: two accepted steps are never back to back.
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> !step);

    // R2: a level that drops leaves no count behind.
    a_r2_break_resets: assert property (@(posedge clk) disable iff (!rst_n)
        !btn |=> (cnt == '0));

endmodule

// File: rtl/pb_wiper_pos.sv
// Wiper position register: a tap code plus two end-scale flags.
// Assumes: at most one of inc and dec is high in any cycle.
// At bottom scale the code reads 0; at top scale it reads CODE_MAX.
module pb_wiper_pos #(
    parameter int CODE_W     = 6,
    parameter int RESET_CODE = 1 << (CODE_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              dec,
    output logic [CODE_W-1:0] code,
    output logic              top,
    output logic              bot
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

    // Apply one up or down step with saturation at the end positions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= CODE_W'(RESET_CODE);
            top  <= 1'b0;
            bot  <= 1'b0;
        end else if (inc) begin
            if (bot)                   bot  <= 1'b0;
            else if (code == CODE_MAX) top  <= 1'b1;
            else if (!top)             code <= code + 1'b1;
        end else if (dec) begin
            if (top)                   top  <= 1'b0;
            else if (code == '0)       bot  <= 1'b1;
            else if (!bot)             code <= code - 1'b1;
        end
    end

    // R11: the end flags are exclusive.
    a_r11_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({top, bot}));

    // R6: top scale absorbs further up steps.
    a_r6_top_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (top && inc) |=> (top && code == CODE_MAX));

    // R7: bottom scale absorbs further down steps.
    a_r7_bot_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (bot && dec) |=> (bot && code == '0));

    // R8: leaving top scale lands on the highest normal code.
    a_r8_top_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (top && dec) |=> (!top && code == CODE_MAX));

    // R9: the step sources never collide.
    a_r9_one_step_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({inc, dec}));

endmodule

// File: rtl/pb_wiper_ctrl.sv
// Top of the push-button wiper stepping controller.
// Two press timers, one for each direction, feed the position register.
// A dual press or the lock input holds both timers cleared.
// Assumes: btn_up, btn_dn and lock are already synchronous to clk.
module pb_wiper_ctrl #(
    parameter int CODE_W   = 6,
    parameter int DEB_CYC  = 8000,
    parameter int HOLD_CYC = 1000000,
    parameter int SCAN_CYC = 140000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_up,
    input  logic              btn_dn,
    input  logic              lock,
    output logic [CODE_W-1:0] wiper_code,
    output logic              at_top,
    output logic              at_bot,
    output logic              at_end
);
    localparam int NBTN = 2;

    logic [NBTN-1:0] btn_lvl;
    logic [NBTN-1:0] btn_step;
    logic            freeze;

    assign btn_lvl = {btn_dn, btn_up};
    assign freeze  = lock || (btn_up && btn_dn);

    // One press timer per direction: index 0 is up, index 1 is down.
    for (genvar g = 0; g < NBTN; g++) begin : g_timer
        pb_press_timer #(
            .DEB_CYC  (DEB_CYC),
            .HOLD_CYC (HOLD_CYC),
            .SCAN_CYC (SCAN_CYC)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .btn      (btn_lvl[g]),
            .hold_off (freeze),
            .step     (btn_step[g])
        );
    end

    pb_wiper_pos #(
        .CODE_W (CODE_W)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (btn_step[0]),
        .dec   (btn_step[1]),
        .code  (wiper_code),
        .top   (at_top),
        .bot   (at_bot)
    );

    assign at_end = at_top || at_bot;

    // R10: a locked cycle leaves the position unchanged.
    a_r10_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable({wiper_code, at_top, at_bot}));

    // R9: a dual press leaves the position unchanged.
    a_r9_dual_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_up && btn_dn) |=> $stable({wiper_code, at_top, at_bot}));

    // R11: end indication matches the flags.
    a_r11_end_flag: assert property (@(posedge clk) disable iff (!rst_n)
        at_end == (at_top || at_bot));

endmodule

// File: tb/sim_pb_wiper_ctrl.sv
// Self-checking bench for pb_wiper_ctrl, with short timer limits.
module sim_pb_wiper_ctrl;
    localparam int DEB  = 8;
    localparam int HOLD = 40;
    localparam int SCAN = 12;
    localparam int NV   = 8;

    // Vector: {buttons[1:0] (bit0 up, bit1 down), high cycles[15:0], exp code[5:0], exp top, exp bot}
    localparam logic [25:0] VEC [NV] = '{
        {2'b01, 16'd7,   6'd32, 1'b0, 1'b0},  // R2 short up ignored
        {2'b01, 16'd8,   6'd33, 1'b0, 1'b0},  // R3 exact debounce
        {2'b10, 16'd8,   6'd32, 1'b0, 1'b0},  // R4 down step
        {2'b01, 16'd47,  6'd33, 1'b0, 1'b0},  // R3 no repeat before hold
        {2'b01, 16'd48,  6'd35, 1'b0, 1'b0},  // R5 first repeat
        {2'b01, 16'd84,  6'd40, 1'b0, 1'b0},  // R5 scan: 5 steps
        {2'b10, 16'd60,  6'd37, 1'b0, 1'b0},  // R4/R5 down scan: 3 steps
        {2'b11, 16'd100, 6'd37, 1'b0, 1'b0}   // R9 both held
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_up = 1'b0;
    logic       btn_dn = 1'b0;
    logic       lock = 1'b0;
    logic [5:0] wiper_code;
    logic       at_top, at_bot, at_end;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    pb_wiper_ctrl #(
        .CODE_W (6), .DEB_CYC (DEB), .HOLD_CYC (HOLD), .SCAN_CYC (SCAN)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .btn_up (btn_up), .btn_dn (btn_dn),
        .lock (lock), .wiper_code (wiper_code), .at_top (at_top),
        .at_bot (at_bot), .at_end (at_end)
    );

    task automatic chk(input string req, input logic [5:0] ec, input logic et, input logic eb);
        n_chk++;
        if (wiper_code !== ec || at_top !== et || at_bot !== eb || at_end !== (et | eb)) begin
            n_bad++;
            $display("FAIL %s: code=%0d top=%b bot=%b end=%b, expected code=%0d top=%b bot=%b end=%b",
                     req, wiper_code, at_top, at_bot, at_end, ec, et, eb, et | eb);
        end
    endtask

    task automatic press(input logic [1:0] b, input int n);
        @(negedge clk);
        btn_up = b[0];
        btn_dn = b[1];
        repeat (n) @(posedge clk);
        @(negedge clk);
        btn_up = 1'b0;
        btn_dn = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", 6'd32, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            press(VEC[i][25:24], int'(VEC[i][23:8]));
            chk($sformatf("vector %0d", i), VEC[i][7:2], VEC[i][1], VEC[i][0]);
        end

        // R6: 37 + 26 steps reach 63, the 27th enters top scale, the rest are absorbed
        press(2'b01, 468);
        chk("R6 top scale saturates", 6'd63, 1'b1, 1'b0);
        // R8: leave top scale
        press(2'b10, 8);
        chk("R8 exit top scale", 6'd63, 1'b0, 1'b0);
        // R7: 64+ down steps from 63 reach bottom scale and saturate
        press(2'b10, 900);
        chk("R7 bottom scale saturates", 6'd0, 1'b0, 1'b1);
        // R8: leave bottom scale
        press(2'b01, 8);
        chk("R8 exit bottom scale", 6'd0, 1'b0, 1'b0);

        // R10: press while locked
        lock = 1'b1;
        press(2'b01, 20);
        lock = 1'b0;
        chk("R10 locked press ignored", 6'd0, 1'b0, 1'b0);

        // R10: lock mid-press clears the count: 5 highs, lock, then 7 highs
        @(negedge clk);
        btn_up = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        lock = 1'b1;
        @(posedge clk);
        @(negedge clk);
        lock = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R10 count restarted after lock", 6'd0, 1'b0, 1'b0);
        btn_up = 1'b0;
        repeat (3) @(negedge clk);

        // R9: both held, then down released; up needs a fresh DEB run
        @(negedge clk);
        btn_up = 1'b1;
        btn_dn = 1'b1;
        repeat (20) @(posedge clk);
        @(negedge clk);
        btn_dn = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R9 no step before fresh debounce", 6'd0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 step after fresh debounce", 6'd1, 1'b0, 1'b0);
        btn_up = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset returns to midscale
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset again", 6'd32, 1'b0, 1'b0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (50000) @(posedge clk);
                if (!done) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL watchdog: run did not complete, expected completion");
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule